// File: doc/BRIEF.md
# Settable Time-of-Day Counter

This block keeps the time of day as hours, minutes and seconds, each held as two BCD digits in 24-hour form. In run mode every one-cycle second strobe moves the seconds on by one. A seconds rollover carries into the minutes, and a minutes rollover carries into the hours. The day wraps from 23:59:59 to 00:00:00. The block hands six BCD digits and a PM flag to a separate display stage. Turning digits into segments and dividing the mains tick down to seconds happen elsewhere.

While the mode input is high the time is frozen and no carry can happen. Three push buttons (hour, minute, second) are each filtered by their own debounce state machine. That machine has the states DB_LOW, DB_RISE, DB_HIGH and DB_FALL, with these transitions:
- DB_LOW to DB_RISE when the synchronised level reads high.
- DB_RISE back to DB_LOW on any low sample.
- DB_RISE to DB_HIGH once the level has stayed high for the stable count. This transition emits the one-cycle press pulse.
- DB_HIGH to DB_FALL on a low sample.
- DB_FALL back to DB_HIGH on a high sample.
- DB_FALL to DB_LOW once the level has stayed low for the stable count.

An accepted press, taken in set mode, bumps only its own field. That field wraps on its own limit and carries nothing.

A display option converts the stored hour into 12-hour form and raises a PM flag. The stored time itself is not changed.

Top module: `hms_timekeeper`

## Requirements
- R1: After reset all six digits read 0 (00:00:00) and pm_flag is 0.
- R2: With set_mode low, a one-cycle high on sec_tick raises the seconds by one, visible after the next rising clock edge.
- R3: In run mode, a tick at second 59 clears the seconds and raises the minutes. At 59:59 it also raises the hours. At 23:59:59 the time becomes 00:00:00.
- R4: With set_mode high, sec_tick has no effect on any digit.
- R5: In set mode, an accepted press of btn_sec, btn_min or btn_hr raises only that field. Seconds and minutes wrap 59 to 0, and hours wrap 23 to 0, with no carry into any other field.
- R6: A button is accepted only after its level has stayed high for at least STABLE_CYCLES clocks (default 4), following a two-flop synchroniser. A high lasting 3 clocks or less is ignored. A press held for 12 clocks gives exactly one increment, no more than 8 clock edges after it rises.
- R7: With set_mode low, button presses leave every digit unchanged.
- R8: With view_12h low, the hour digits equal the stored 24-hour value and pm_flag is 0.
- R9: With view_12h high, stored hour 0 is shown as 12, hours 1 to 12 are shown unchanged, and 13 to 23 are shown as 1 to 11. pm_flag is 1 exactly when the stored hour is 12 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle strobe marking a second boundary |
| set_mode | input | 1 | 1 = freeze time and allow button edits, 0 = run |
| btn_hr | input | 1 | Raw hour button, active high |
| btn_min | input | 1 | Raw minute button, active high |
| btn_sec | input | 1 | Raw second button, active high |
| view_12h | input | 1 | 1 = show the hour in 12-hour form |
| hr_tens | output | 4 | Displayed hour tens digit (BCD) |
| hr_ones | output | 4 | Displayed hour ones digit (BCD) |
| min_tens | output | 4 | Minute tens digit (BCD) |
| min_ones | output | 4 | Minute ones digit (BCD) |
| sec_tens | output | 4 | Second tens digit (BCD) |
| sec_ones | output | 4 | Second ones digit (BCD) |
| pm_flag | output | 1 | PM indicator in 12-hour view |

## Verification
A tick result is due one clock edge after sec_tick is sampled high. The bench raises sec_tick on a falling edge, lowers it on the next falling edge, and compares the digits there, half a cycle after the update. A button result is due within eight edges of the raw rise: two synchroniser stages, four stable samples, the pulse register and the counter. Each press is therefore held for twelve clocks and released for twelve before the comparison. The 12-hour view and pm_flag are combinational from the stored hour, so they are checked on the falling edge right after view_12h changes.

// File: rtl/hms_pkg.sv
package hms_pkg;
    typedef logic [3:0] bcd_t;

    typedef enum logic [1:0] {
        DB_LOW,
        DB_RISE,
        DB_HIGH,
        DB_FALL
    } db_state_e;

    localparam int BTN_COUNT = 3;
    localparam int BTN_SEC   = 0;
    localparam int BTN_MIN   = 1;
    localparam int BTN_HR    = 2;
endpackage

// File: rtl/btn_debounce.sv
module btn_debounce
    import hms_pkg::*;
#(
    parameter int STABLE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic press
);
    localparam int CW = $clog2(STABLE_CYCLES + 1);
    localparam logic [CW-1:0] CNT_DONE = CW'(STABLE_CYCLES - 1);

    logic      sync1, sync2;
    db_state_e state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
        end else begin
            sync1 <= raw;
            sync2 <= sync1;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= DB_LOW;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            DB_LOW: begin
                if (sync2) begin
                    state_nx = DB_RISE;
                    cnt_nx   = CW'(1);
                end
            end
            DB_RISE: begin
                if (!sync2)                state_nx = DB_LOW;
                else if (cnt == CNT_DONE)  state_nx = DB_HIGH;
                else                       cnt_nx   = cnt + CW'(1);
            end
            DB_HIGH: begin
                if (!sync2) begin
                    state_nx = DB_FALL;
                    cnt_nx   = CW'(1);
                end
            end
            DB_FALL: begin
                if (sync2)                 state_nx = DB_HIGH;
                else if (cnt == CNT_DONE)  state_nx = DB_LOW;
                else                       cnt_nx   = cnt + CW'(1);
            end
            default: state_nx = DB_LOW;
        endcase
    end

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) press <= 1'b0;
        else        press <= (state == DB_RISE) && (state_nx == DB_HIGH);
    end

    // R6: an accepted press is a single-cycle pulse
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        press |=> !press);
    // R6: a pulse follows only a completed stable-high window
    a_r6_pulse_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        press |-> state == DB_HIGH);
endmodule

// File: rtl/bcd_wrap_counter.sv
module bcd_wrap_counter
    import hms_pkg::*;
#(
    parameter int LAST_TENS = 5,
    parameter int LAST_ONES = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    output bcd_t tens,
    output bcd_t ones,
    output logic at_last
);
    localparam bcd_t TOP_T = 4'(LAST_TENS);
    localparam bcd_t TOP_O = 4'(LAST_ONES);

    assign at_last = (tens == TOP_T) && (ones == TOP_O);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tens <= '0;
            ones <= '0;
        end else if (inc) begin
            if (at_last) begin
                tens <= '0;
                ones <= '0;
            end else if (ones == 4'd9) begin
                tens <= tens + 4'd1;
                ones <= '0;
            end else begin
                ones <= ones + 4'd1;
            end
        end
    end

    // R3/R5: value always a legal BCD pair within the field limit
    a_r3_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
        ones <= 4'd9 && {tens, ones} <= {TOP_T, TOP_O});
    // R5: a field at its limit returns to zero when bumped
    a_r5_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        inc && at_last |=> tens == 4'd0 && ones == 4'd0);
endmodule

// File: rtl/hour_view.sv
module hour_view
    import hms_pkg::*;
(
    input  bcd_t hr_tens_in,
    input  bcd_t hr_ones_in,
    input  logic view_12h,
    output bcd_t hr_tens_out,
    output bcd_t hr_ones_out,
    output logic pm
);
    logic [4:0] hr_bin;
    logic [4:0] hr_disp;

    always_comb begin
        hr_bin = 5'(hr_tens_in) * 5'd10 + 5'(hr_ones_in);
        pm     = 1'b0;
        if (!view_12h) begin
            hr_disp = hr_bin;
        end else begin
            pm = (hr_bin >= 5'd12);
            if (hr_bin == 5'd0)       hr_disp = 5'd12;
            else if (hr_bin > 5'd12)  hr_disp = hr_bin - 5'd12;
            else                      hr_disp = hr_bin;
        end
        if (hr_disp >= 5'd20) begin
            hr_tens_out = 4'd2;
            hr_ones_out = 4'(hr_disp - 5'd20);
        end else if (hr_disp >= 5'd10) begin
            hr_tens_out = 4'd1;
            hr_ones_out = 4'(hr_disp - 5'd10);
        end else begin
            hr_tens_out = 4'd0;
            hr_ones_out = 4'(hr_disp);
        end
    end

    // R9: 12-hour view never shows zero or more than twelve
    always_comb begin
        if (view_12h)
            a_r9_range: assert (hr_disp >= 5'd1 && hr_disp <= 5'd12);
    end
endmodule

// File: rtl/hms_timekeeper.sv
module hms_timekeeper
    import hms_pkg::*;
#(
    parameter int STABLE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_tick,
    input  logic set_mode,
    input  logic btn_hr,
    input  logic btn_min,
    input  logic btn_sec,
    input  logic view_12h,
    output logic [3:0] hr_tens,
    output logic [3:0] hr_ones,
    output logic [3:0] min_tens,
    output logic [3:0] min_ones,
    output logic [3:0] sec_tens,
    output logic [3:0] sec_ones,
    output logic pm_flag
);
    logic [BTN_COUNT-1:0] raw_btn, press;
    logic [BTN_COUNT-1:0] bump;
    logic run_tick;
    logic s_last, m_last, h_last;
    logic inc_s, inc_m, inc_h;
    bcd_t h_t, h_o;

    assign raw_btn[BTN_SEC] = btn_sec;
    assign raw_btn[BTN_MIN] = btn_min;
    assign raw_btn[BTN_HR]  = btn_hr;

    for (genvar i = 0; i < BTN_COUNT; i++) begin : g_btn
        btn_debounce #(.STABLE_CYCLES(STABLE_CYCLES)) u_db (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (raw_btn[i]),
            .press (press[i])
        );
    end

    assign bump     = set_mode ? press : '0;
    assign run_tick = !set_mode && sec_tick;
    assign inc_s    = run_tick || bump[BTN_SEC];
    assign inc_m    = (run_tick && s_last) || bump[BTN_MIN];
    assign inc_h    = (run_tick && s_last && m_last) || bump[BTN_HR];

    bcd_wrap_counter #(.LAST_TENS(5), .LAST_ONES(9)) u_sec (
        .clk(clk), .rst_n(rst_n), .inc(inc_s),
        .tens(sec_tens), .ones(sec_ones), .at_last(s_last)
    );
    bcd_wrap_counter #(.LAST_TENS(5), .LAST_ONES(9)) u_min (
        .clk(clk), .rst_n(rst_n), .inc(inc_m),
        .tens(min_tens), .ones(min_ones), .at_last(m_last)
    );
    bcd_wrap_counter #(.LAST_TENS(2), .LAST_ONES(3)) u_hr (
        .clk(clk), .rst_n(rst_n), .inc(inc_h),
        .tens(h_t), .ones(h_o), .at_last(h_last)
    );

    hour_view u_view (
        .hr_tens_in  (h_t),
        .hr_ones_in  (h_o),
        .view_12h    (view_12h),
        .hr_tens_out (hr_tens),
        .hr_ones_out (hr_ones),
        .pm          (pm_flag)
    );

    logic [6:0] sec_val;
    assign sec_val = 7'(sec_tens) * 7'd10 + 7'(sec_ones);

    // R2: a run tick below 59 steps seconds by one
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        !set_mode && sec_tick && !s_last |=> sec_val == $past(sec_val) + 7'd1);
    // R3: full-day rollover returns to midnight
    a_r3_midnight: assert property (@(posedge clk) disable iff (!rst_n)
        run_tick && s_last && m_last && h_last
        |=> h_t == 4'd0 && h_o == 4'd0 && min_tens == 4'd0 && min_ones == 4'd0);
    // R4: set mode without presses freezes all digits
    a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        set_mode && press == '0
        |=> $stable(sec_ones) && $stable(sec_tens) && $stable(min_ones)
            && $stable(min_tens) && $stable(h_o) && $stable(h_t));
    // R5: a seconds press alone never carries into minutes or hours
    a_r5_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
        set_mode && press == 3'b001 |=> $stable(min_ones) && $stable(min_tens)
            && $stable(h_o) && $stable(h_t));
    // R7: presses in run mode without a tick change nothing
    a_r7_run_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        !set_mode && !sec_tick |=> $stable(sec_ones) && $stable(min_ones) && $stable(h_o));
    // R8/R9: PM only in 12-hour view
    a_r8_pm_gated: assert property (@(posedge clk) disable iff (!rst_n)
        pm_flag |-> view_12h);
endmodule

// File: tb/hms_timekeeper_bench.sv
module hms_timekeeper_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sec_tick = 1'b0, set_mode = 1'b0, view_12h = 1'b0;
    logic btn_hr = 1'b0, btn_min = 1'b0, btn_sec = 1'b0;
    logic [3:0] hr_tens, hr_ones, min_tens, min_ones, sec_tens, sec_ones;
    logic pm_flag;

    int checks = 0;
    int fails = 0;
    int eh = 0, em = 0, es = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hms_timekeeper u_hms_timekeeper (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .set_mode(set_mode),
        .btn_hr(btn_hr), .btn_min(btn_min), .btn_sec(btn_sec), .view_12h(view_12h),
        .hr_tens(hr_tens), .hr_ones(hr_ones), .min_tens(min_tens), .min_ones(min_ones),
        .sec_tens(sec_tens), .sec_ones(sec_ones), .pm_flag(pm_flag)
    );

    function automatic int shown_hour(int h, bit v12);
        if (!v12) return h;
        if (h == 0) return 12;
        if (h > 12) return h - 12;
        return h;
    endfunction

    function automatic bit exp_pm(int h, bit v12);
        return v12 && (h >= 12);
    endfunction

    task automatic check(string req);
        int ah, am, as_, xh;
        bit xp;
        ah = hr_tens * 10 + hr_ones;
        am = min_tens * 10 + min_ones;
        as_ = sec_tens * 10 + sec_ones;
        xh = shown_hour(eh, view_12h);
        xp = exp_pm(eh, view_12h);
        checks++;
        if (ah != xh || am != em || as_ != es || pm_flag != xp ||
            hr_ones > 9 || min_ones > 9 || sec_ones > 9) begin
            fails++;
            $display("FAIL %s: got %0d:%0d:%0d pm=%0d, expected %0d:%0d:%0d pm=%0d",
                     req, ah, am, as_, pm_flag, xh, em, es, xp);
        end
    endtask

    task automatic tick();
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        if (!set_mode) begin
            es++;
            if (es == 60) begin
                es = 0; em++;
                if (em == 60) begin
                    em = 0; eh = (eh + 1) % 24;
                end
            end
        end
    endtask

    task automatic press(int which, int hold);
        if (which == 0) btn_sec = 1'b1;
        else if (which == 1) btn_min = 1'b1;
        else btn_hr = 1'b1;
        repeat (hold) @(negedge clk);
        btn_sec = 1'b0; btn_min = 1'b0; btn_hr = 1'b0;
        repeat (12) @(negedge clk);
        if (set_mode && hold >= 8) begin
            if (which == 0) es = (es + 1) % 60;
            else if (which == 1) em = (em + 1) % 60;
            else eh = (eh + 1) % 24;
        end
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > WATCHDOG) begin
                fails++;
                checks++;
                $display("FAIL watchdog: got %0d cycles, expected at most %0d", cyc, WATCHDOG);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release");

        // R2 basic ticks
        repeat (5) tick();
        check("R2 tick steps seconds");

        // R3 carry into minutes
        repeat (55) tick();
        check("R3 seconds to minutes");

        // R4 ticks ignored in set mode
        set_mode = 1'b1;
        @(negedge clk);
        repeat (4) tick();
        check("R4 tick frozen in set mode");

        // R6 short glitch ignored
        press(0, 3);
        check("R6 three-cycle glitch ignored");
        press(0, 12);
        check("R6 press accepted once");

        // R5 set to 23:59:59 with presses, no carries
        while (es != 59) press(0, 12);
        check("R5 seconds at 59");
        press(0, 12);
        check("R5 seconds wrap without carry");
        while (es != 59) press(0, 12);
        while (em != 59) press(1, 12);
        press(1, 12);
        check("R5 minutes wrap without carry");
        while (em != 59) press(1, 12);
        while (eh != 23) press(2, 12);
        check("R5 hours at 23");
        view_12h = 1'b1;
        @(negedge clk);
        check("R9 hour 23 shown as 11 PM");
        press(2, 12);
        check("R9 hour 0 shown as 12 AM");
        view_12h = 1'b0;
        @(negedge clk);
        check("R8 hour 0 in 24-hour view");
        while (eh != 23) press(2, 12);
        check("R5 back at 23:59:59");

        // R7 run mode presses ignored; R3 midnight rollover
        set_mode = 1'b0;
        @(negedge clk);
        press(2, 12);
        press(1, 12);
        check("R7 presses ignored in run mode");
        tick();
        check("R3 midnight rollover");

        // R9 walk hours 11..13 in 12-hour view
        set_mode = 1'b1;
        view_12h = 1'b1;
        @(negedge clk);
        while (eh != 11) press(2, 12);
        check("R9 hour 11 AM");
        press(2, 12);
        check("R9 hour 12 PM");
        press(2, 12);
        check("R9 hour 13 shown as 1 PM");

        // random mix
        for (int i = 0; i < 300; i++) begin
            int op;
            op = int'($urandom % 6);
            if (op <= 2) begin
                set_mode = 1'b0;
                @(negedge clk);
                tick();
                check("R2 random tick");
            end else if (op == 3) begin
                set_mode = 1'b1;
                @(negedge clk);
                press(int'($urandom % 3), 12);
                check("R5 random press");
            end else if (op == 4) begin
                view_12h = ~view_12h;
                @(negedge clk);
                check(view_12h ? "R9 random view" : "R8 random view");
            end else begin
                set_mode = $urandom % 2;
                @(negedge clk);
                tick();
                check(set_mode ? "R4 random frozen tick" : "R3 random tick");
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule